// File: doc/BRIEF.md
# SD host command issue engine

This block turns one command request into the register-level programming sequence that an SD host controller expects before and after a command goes out on the bus. A requester hands over a command index, a 32-bit argument, a block count, a flag for commands that move data, a two-bit response type and a flag for application-specific commands. The engine then runs the whole sequence on a simple register port: single-cycle writes, and reads whose data returns one cycle after the read strobe. It reports pass or fail with a one-cycle done pulse.

The engine first reads the controller's present-state register. If the command line is busy, the request fails at once. Otherwise it programs the block count, the timeout control and the argument. It clears stale normal and error status and reads the present state again. It refuses a data command while the data lines are busy. It then writes the command register and polls the normal status register. A configurable poll limit keeps the engine from waiting forever on a silent controller.

Top module: `sdcmd_seq`

## Requirements
- R1: `req_ready_o` is high only while the engine is idle, and a request is taken when `req_valid_i` and `req_ready_o` are both high. Every request ends with `done_o` high for exactly one cycle, with `pass_o` valid in that cycle. The engine is ready again in the next cycle.
- R2: The first action is a read of the present-state register (address 0x00). If its bit 0 (command busy) is set, the request fails and no register is written.
- R3: Otherwise the writes come in this fixed order: block count (0x04), timeout control (0x08), argument (0x0C), normal status (0x14), error status (0x18), command (0x10), then at most one status write after polling.
- R4: The timeout control register is written with 0x0000000E on every command that gets past the first busy check.
- R5: Before the command register is written, both status registers are written with 0x0000FFFF, which clears every bit.
- R6: The internal command word holds the index in bits 13:8, the data flag in bit 5, the response type in bits 1:0 and the application flag in bit 31. Only its low 14 bits are written to the command register, so bits 31:14 of that write are always zero.
- R7: After the clears, the present state is read again. If bit 1 (data busy) is set and the data flag is set, the request fails before the command write. A clear data flag ignores bit 1.
- R8: The normal status register is polled after the command write. If bit 15 (error summary) is seen, the error status register is written with 0x0000FFFF and the request fails. The error bit wins when bits 15 and 0 show up together.
- R9: When bit 0 (command complete) is seen without an error, only that bit is cleared: the normal status register is written with 0x00000001, and the request passes.
- R10: After `POLL_LIMIT` status reads that show neither bit, the request fails with no further read or write.
- R11: After reset the engine is idle: ready high, done low, no register strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle and able to take a request |
| req_idx_i | input | 6 | Command index |
| req_app_i | input | 1 | Application-specific command flag |
| req_arg_i | input | 32 | Command argument |
| req_blkcnt_i | input | 16 | Block count |
| req_data_i | input | 1 | Command uses the data lines |
| req_resp_i | input | 2 | Response type code |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, valid with done_o |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Read data, valid the cycle after reg_rd_o |

## Verification
The assertions assume the controller port answers every read exactly one cycle later. They also assume the requester holds the request fields steady only up to acceptance; after acceptance the engine works from its own latched copy. The bench models the controller with a register stage that fills `reg_rdata_i` on the edge that samples the read strobe. It changes the present-state and poll script only between requests, while the engine is idle. The sweep covers every mix of both busy bits, the data flag, the application flag and four poll outcomes. Each outcome fires after one to three reads, which keeps it inside the poll limit except in the silent case.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 14;
  localparam int IDX_W  = 6;
  localparam int BCNT_W = 16;
  localparam int RESP_W = 2;

  localparam logic [ADDR_W-1:0] A_STATE  = 8'h00;
  localparam logic [ADDR_W-1:0] A_BLKCNT = 8'h04;
  localparam logic [ADDR_W-1:0] A_TOUT   = 8'h08;
  localparam logic [ADDR_W-1:0] A_ARG    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CMD    = 8'h10;
  localparam logic [ADDR_W-1:0] A_NSTS   = 8'h14;
  localparam logic [ADDR_W-1:0] A_ESTS   = 8'h18;

  localparam int ST_CMD_BUSY = 0;
  localparam int ST_DAT_BUSY = 1;
  localparam int NS_DONE     = 0;
  localparam int NS_ERR      = 15;
  localparam int CF_DATA     = 5;
  localparam int CF_APP      = 31;

  localparam logic [DATA_W-1:0] TOUT_VAL = 32'h0000_000E;
  localparam logic [DATA_W-1:0] CLR_ALL  = 32'h0000_FFFF;
  localparam logic [DATA_W-1:0] CLR_DONE = 32'h0000_0001;

  typedef enum logic [3:0] {
    S_IDLE, S_RD1, S_CHK1, S_WBLK, S_WTO, S_WARG, S_WNCLR, S_WECLR,
    S_RD2, S_CHK2, S_WCMD, S_PRD, S_PCHK, S_WEFAIL, S_WCC, S_FIN
  } seq_e;
endpackage

// File: rtl/sdcmd_frame.sv
module sdcmd_frame
  import sdcmd_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              app_i,
  input  logic              data_i,
  input  logic [RESP_W-1:0] resp_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] field_o
);
  localparam logic [DATA_W-1:0] FIELD_MASK = (DATA_W)'((64'd1 << CMD_W) - 64'd1);

  always_comb begin
    word_o              = '0;
    word_o[13:8]        = idx_i;
    word_o[CF_DATA]     = data_i;
    word_o[RESP_W-1:0]  = resp_i;
    word_o[CF_APP]      = app_i;
  end

  // app flag is software-side only; strip to the register width
  assign field_o = word_o & FIELD_MASK;
endmodule

// File: rtl/sdcmd_poll_timer.sv
module sdcmd_poll_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [5:0]        req_idx_i,
  input  logic              req_app_i,
  input  logic [31:0]       req_arg_i,
  input  logic [15:0]       req_blkcnt_i,
  input  logic              req_data_i,
  input  logic [1:0]        req_resp_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [7:0]        reg_addr_o,
  output logic [31:0]       reg_wdata_o,
  input  logic [31:0]       reg_rdata_i
);
  seq_e state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic              app_q, data_q, pass_q;
  logic [RESP_W-1:0] resp_q;
  logic [DATA_W-1:0] arg_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [DATA_W-1:0] word_w, field_w;
  logic              accept, expired;

  assign accept = req_valid_i && req_ready_o;

  sdcmd_frame u_frame (
    .idx_i(idx_q), .app_i(app_q), .data_i(data_q), .resp_i(resp_q),
    .word_o(word_w), .field_o(field_w)
  );

  sdcmd_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_q == S_WCMD),
    .tick_i(state_q == S_PRD),
    .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      app_q   <= 1'b0;
      data_q  <= 1'b0;
      resp_q  <= '0;
      arg_q   <= '0;
      bcnt_q  <= '0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q  <= req_idx_i;
        app_q  <= req_app_i;
        data_q <= req_data_i;
        resp_q <= req_resp_i;
        arg_q  <= req_arg_i;
        bcnt_q <= req_blkcnt_i;
        pass_q <= 1'b0;
      end else if (state_q == S_WCC) begin
        pass_q <= 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (req_valid_i) state_d = S_RD1;
      S_RD1:    state_d = S_CHK1;
      S_CHK1:   state_d = reg_rdata_i[ST_CMD_BUSY] ? S_FIN : S_WBLK;
      S_WBLK:   state_d = S_WTO;
      S_WTO:    state_d = S_WARG;
      S_WARG:   state_d = S_WNCLR;
      S_WNCLR:  state_d = S_WECLR;
      S_WECLR:  state_d = S_RD2;
      S_RD2:    state_d = S_CHK2;
      S_CHK2:   state_d = (reg_rdata_i[ST_DAT_BUSY] && word_w[CF_DATA]) ? S_FIN : S_WCMD;
      S_WCMD:   state_d = S_PRD;
      S_PRD:    state_d = S_PCHK;
      S_PCHK: begin
        if (reg_rdata_i[NS_ERR])       state_d = S_WEFAIL;
        else if (reg_rdata_i[NS_DONE]) state_d = S_WCC;
        else if (expired)              state_d = S_FIN;
        else                           state_d = S_PRD;
      end
      S_WEFAIL: state_d = S_FIN;
      S_WCC:    state_d = S_FIN;
      S_FIN:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_comb begin
    reg_wr_o    = 1'b0;
    reg_rd_o    = 1'b0;
    reg_addr_o  = '0;
    reg_wdata_o = '0;
    unique case (state_q)
      S_RD1, S_RD2: begin reg_rd_o = 1'b1; reg_addr_o = A_STATE; end
      S_PRD:        begin reg_rd_o = 1'b1; reg_addr_o = A_NSTS;  end
      S_WBLK:   begin reg_wr_o = 1'b1; reg_addr_o = A_BLKCNT; reg_wdata_o = DATA_W'(bcnt_q); end
      S_WTO:    begin reg_wr_o = 1'b1; reg_addr_o = A_TOUT;   reg_wdata_o = TOUT_VAL; end
      S_WARG:   begin reg_wr_o = 1'b1; reg_addr_o = A_ARG;    reg_wdata_o = arg_q; end
      S_WNCLR:  begin reg_wr_o = 1'b1; reg_addr_o = A_NSTS;   reg_wdata_o = CLR_ALL; end
      S_WECLR,
      S_WEFAIL: begin reg_wr_o = 1'b1; reg_addr_o = A_ESTS;   reg_wdata_o = CLR_ALL; end
      S_WCMD:   begin reg_wr_o = 1'b1; reg_addr_o = A_CMD;    reg_wdata_o = field_w; end
      S_WCC:    begin reg_wr_o = 1'b1; reg_addr_o = A_NSTS;   reg_wdata_o = CLR_DONE; end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign pass_o      = done_o && pass_q;
endmodule

// File: rtl/sdcmd_seq_chk.sv
module sdcmd_seq_chk
  import sdcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        pass_o,
  input logic        reg_wr_o,
  input logic        reg_rd_o,
  input logic [7:0]  reg_addr_o,
  input logic [31:0] reg_wdata_o,
  input logic [31:0] reg_rdata_i
);
  logic        first_pend, rd_st_q, inh_now;
  logic [31:0] polls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_pend <= 1'b0;
      rd_st_q    <= 1'b0;
      polls      <= '0;
    end else begin
      rd_st_q <= reg_rd_o && reg_addr_o == A_STATE;
      if (req_valid_i && req_ready_o)  first_pend <= 1'b1;
      else if (rd_st_q)                first_pend <= 1'b0;
      if (req_valid_i && req_ready_o)            polls <= '0;
      else if (reg_rd_o && reg_addr_o == A_NSTS) polls <= polls + 1;
    end
  end

  assign inh_now = rd_st_q && first_pend && reg_rdata_i[ST_CMD_BUSY];

  assert_ready_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !reg_wr_o && !reg_rd_o);
  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));
  assert_busy_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_now |=> done_o && !pass_o && !reg_wr_o);
  assert_timeout_val_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == A_TOUT) |-> reg_wdata_o == TOUT_VAL);
  assert_cmd_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == A_CMD) |-> reg_wdata_o[31:14] == '0);
  assert_done_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == A_NSTS && reg_wdata_o != CLR_ALL) |-> reg_wdata_o == CLR_DONE);
  assert_pass_after_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(reg_wr_o && reg_addr_o == A_NSTS && reg_wdata_o == CLR_DONE));
  assert_poll_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls <= 32'(POLL_LIMIT));
endmodule

bind sdcmd_seq sdcmd_seq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (.*);

// File: tb/sdcmd_seq_bench.sv
module sdcmd_seq_bench;
  localparam int PL = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [5:0]  req_idx = '0;
  logic        req_app = 1'b0, req_data = 1'b0;
  logic [31:0] req_arg = '0;
  logic [15:0] req_blkcnt = '0;
  logic [1:0]  req_resp = '0;
  logic        done, pass;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  sdcmd_seq #(.POLL_LIMIT(PL)) u_sdcmd_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_idx_i(req_idx), .req_app_i(req_app), .req_arg_i(req_arg),
    .req_blkcnt_i(req_blkcnt), .req_data_i(req_data), .req_resp_i(req_resp),
    .done_o(done), .pass_o(pass),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  // controller model
  logic [1:0]  st_val = '0;
  int          mode = 0, hit_k = 1;
  int          poll_n = 0;
  int          log_n = 0;
  int          rd_n = 0;
  logic [7:0]  log_a [1024];
  logic [31:0] log_d [1024];

  always @(posedge clk) begin
    if (reg_rd) begin
      rd_n <= rd_n + 1;
      if (reg_addr == 8'h00) reg_rdata <= {30'b0, st_val};
      else if (reg_addr == 8'h14) begin
        poll_n <= poll_n + 1;
        if (mode != 3 && poll_n + 1 >= hit_k)
          reg_rdata <= (mode == 0) ? 32'h0001 : (mode == 1) ? 32'h8000 : 32'h8001;
        else reg_rdata <= 32'h0;
      end else reg_rdata <= 32'h0;
    end
    if (reg_wr) begin
      log_a[log_n] <= reg_addr;
      log_d[log_n] <= reg_wdata;
      log_n <= log_n + 1;
      if (reg_addr == 8'h10) poll_n <= 0;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    reg_rdata = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready && !done && !reg_wr && !reg_rd, "R11 reset idle",
        {28'b0, req_ready, done, reg_wr, reg_rd}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !reg_wr && !reg_rd, "R11 idle after release",
        {28'b0, req_ready, done, reg_wr, reg_rd}, 32'h8);

    for (int t = 0; t < 64; t++) begin
      logic [7:0]  ea [8];
      logic [31:0] ed [8];
      logic [31:0] fw;
      int          en, base, g;
      bit          exp_pass, dp;
      string       tg;

      st_val = t[1:0];
      dp     = t[2];
      mode   = t / 16;
      hit_k  = (t % 3) + 1;
      req_idx    = 6'((t * 7) % 64);
      req_app    = t[3];
      req_data   = dp;
      req_resp   = 2'(t % 4);
      req_arg    = 32'hA500_0000 ^ (32'(t) * 32'h0101_0101);
      req_blkcnt = 16'(t * 3 + 1);

      fw = {18'b0, req_idx, 2'b00, dp, 3'b000, req_resp};
      en = 0;
      if (!st_val[0]) begin
        ea[0] = 8'h04; ed[0] = {16'b0, req_blkcnt};
        ea[1] = 8'h08; ed[1] = 32'h0E;
        ea[2] = 8'h0C; ed[2] = req_arg;
        ea[3] = 8'h14; ed[3] = 32'hFFFF;
        ea[4] = 8'h18; ed[4] = 32'hFFFF;
        en = 5;
        if (!(st_val[1] && dp)) begin
          ea[5] = 8'h10; ed[5] = fw; en = 6;
          if (mode == 0)      begin ea[6] = 8'h14; ed[6] = 32'h1;    en = 7; end
          else if (mode != 3) begin ea[6] = 8'h18; ed[6] = 32'hFFFF; en = 7; end
        end
      end
      exp_pass = !st_val[0] && !(st_val[1] && dp) && mode == 0;
      if (st_val[0])             tg = "R2";
      else if (st_val[1] && dp)  tg = "R7";
      else if (mode == 3)        tg = "R10";
      else if (mode != 0)        tg = "R8";
      else                       tg = "R9";

      base = log_n;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      g = 0;
      while (!done && g < 200) begin @(negedge clk); g++; end
      chk(done && pass == exp_pass, $sformatf("%s result t=%0d", tg, t),
          {30'b0, done, pass}, {30'b0, 1'b1, exp_pass});
      chk(log_n - base == en, $sformatf("R3 write count t=%0d", t),
          32'(log_n - base), 32'(en));
      for (int i = 0; i < en && i < log_n - base; i++) begin
        string et;
        case (i)
          1: et = "R4"; 3, 4: et = "R5"; 5: et = "R6";
          6: et = (mode == 0) ? "R9" : "R8";
          default: et = "R3";
        endcase
        chk(log_a[base + i] == ea[i] && log_d[base + i] == ed[i],
            $sformatf("%s write %0d t=%0d", et, i, t),
            {log_a[base + i], log_d[base + i][23:0]}, {ea[i], ed[i][23:0]});
      end
      @(negedge clk);
      chk(!done && req_ready, $sformatf("R1 pulse t=%0d", t),
          {30'b0, done, req_ready}, 32'h1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule